// File: doc/BRIEF.md
# AXI4-to-AXI3 Write Burst Bridge

This block joins an AXI4 manager to an AXI3 subordinate on the write path only. It carries the AW, W and B channels. It takes one AXI4 INCR write burst at a time, with a length of up to 256 beats. It replays that burst downstream as a run of AXI3 sub-bursts, each no longer than 16 beats, issued in strict order.

Each sub-burst gets its own address phase. Every data beat carries a write-data ID equal to the burst's AWID, and WLAST is regenerated at the end of every sub-burst. Downstream, the subordinate returns one write response per sub-burst. The bridge folds these into a single response to the manager, and only when the last of them has arrived.

The two attribute fields that AXI3 lacks, quality-of-service and region, are accepted upstream and then discarded. The single AXI4 lock bit is re-encoded as the AXI3 exclusive code.

Top module: `axi4to3_wr_bridge`

## Requirements
- R1: An upstream burst with AWLEN = L is issued as floor(L/16)+1 sub-bursts. Every sub-burst except the last has m_awlen = 15, and the last has m_awlen = L mod 16. A burst of 16 beats or fewer is therefore issued once, with its length unchanged.
- R2: Sub-burst k (counting from 0) starts at address s_awaddr + k·16·2^AWSIZE.
- R3: Every sub-burst copies AWID, AWSIZE, AWBURST, AWCACHE and AWPROT. An upstream lock bit of 1 gives m_awlock = 2'b01 (exclusive) and 0 gives 2'b00; the code 2'b10 (locked) never appears.
- R4: The values on s_awqos and s_awregion have no effect on any downstream output.
- R5: Write data and strobes pass downstream in order with no interleaving, and m_wid equals the burst's AWID on every beat.
- R6: m_wlast is high on beat 16·j+15 of the burst (beats counted from 0), and also on the final beat of the burst. It is low on all other beats.
- R7: Exactly one s_bvalid handshake occurs per upstream burst. It arrives only after every sub-burst response has been accepted, and it carries s_bid = AWID.
- R8: s_bresp is the highest code among the sub-burst responses, using the order OKAY 2'b00 < EXOKAY 2'b01 < SLVERR 2'b10 < DECERR 2'b11.
- R9: Once m_awvalid or s_bvalid is raised, it stays high with a stable payload until the matching READY is seen.
- R10: s_awready is low from the cycle after an AW handshake until the merged B response has been accepted.
- R11: After reset, s_awready is 1 and m_awvalid, m_wvalid, s_wready and s_bvalid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awid | input | IDW | Upstream write ID |
| s_awaddr | input | AW | Upstream start address |
| s_awlen | input | 8 | Upstream burst length minus one |
| s_awsize | input | 3 | Beat size, log2 bytes |
| s_awburst | input | 2 | Burst type |
| s_awlock | input | 1 | Exclusive access flag |
| s_awcache | input | 4 | Cache attributes |
| s_awprot | input | 3 | Protection attributes |
| s_awqos | input | 4 | Quality-of-service field (discarded) |
| s_awregion | input | 4 | Region field (discarded) |
| s_awvalid | input | 1 | Upstream address valid |
| s_awready | output | 1 | Upstream address ready |
| s_wdata | input | DW | Upstream write data |
| s_wstrb | input | DW/8 | Upstream byte strobes |
| s_wlast | input | 1 | Upstream last beat of burst |
| s_wvalid | input | 1 | Upstream data valid |
| s_wready | output | 1 | Upstream data ready |
| s_bid | output | IDW | Merged response ID |
| s_bresp | output | 2 | Merged response code |
| s_bvalid | output | 1 | Merged response valid |
| s_bready | input | 1 | Merged response ready |
| m_awid | output | IDW | Sub-burst ID |
| m_awaddr | output | AW | Sub-burst start address |
| m_awlen | output | 4 | Sub-burst length minus one |
| m_awsize | output | 3 | Beat size |
| m_awburst | output | 2 | Burst type |
| m_awlock | output | 2 | AXI3 lock code |
| m_awcache | output | 4 | Cache attributes |
| m_awprot | output | 3 | Protection attributes |
| m_awvalid | output | 1 | Sub-burst address valid |
| m_awready | input | 1 | Sub-burst address ready |
| m_wid | output | IDW | Write-data ID |
| m_wdata | output | DW | Write data |
| m_wstrb | output | DW/8 | Byte strobes |
| m_wlast | output | 1 | Last beat of sub-burst |
| m_wvalid | output | 1 | Data valid |
| m_wready | input | 1 | Data ready |
| m_bid | input | IDW | Sub-burst response ID |
| m_bresp | input | 2 | Sub-burst response code |
| m_bvalid | input | 1 | Sub-burst response valid |
| m_bready | output | 1 | Sub-burst response ready |

## Verification
The hardest case to reach is a mixed severity merge across many sub-bursts, where the worst code is not the last one returned. The case that needs it is a maximum 256-beat burst split into sixteen pieces. Short bursts never produce more than one response, so they cannot show this. The bench scripts a per-sub-burst response plan with SLVERR and DECERR placed mid-sequence. It also throttles the downstream AW and W ready lines on different cadences, so that address issue, data beats and responses drift out of step with one another. Under that drift, the stability of the held address, the sub-burst WLAST positions and the timing of the single merged response are all observed.

// File: rtl/bsb_pkg.sv
package bsb_pkg;
    localparam int SUB_BEATS = 16;
    localparam int LEN3_W    = 4;
    localparam int LEN4_W    = 8;
    localparam int NSUB_W    = LEN4_W - LEN3_W + 1;
    localparam int BEAT_W    = LEN4_W + 1;

    typedef enum logic [1:0] {
        RSP_OKAY   = 2'b00,
        RSP_EXOKAY = 2'b01,
        RSP_SLVERR = 2'b10,
        RSP_DECERR = 2'b11
    } rsp_e;

    function automatic logic [1:0] rsp_worse(input logic [1:0] a, input logic [1:0] b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/bsb_aw_split.sv
module bsb_aw_split
    import bsb_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [AW-1:0]     start_addr,
    input  logic [LEN4_W-1:0] start_len,
    input  logic [2:0]        beat_size,
    output logic [AW-1:0]     m_awaddr,
    output logic [LEN3_W-1:0] m_awlen,
    output logic              m_awvalid,
    input  logic              m_awready
);
    typedef struct packed {
        logic [AW-1:0]     addr;
        logic [NSUB_W-1:0] left;
        logic [LEN3_W-1:0] tail;
        logic              valid;
    } split_t;

    split_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.addr  = start_addr;
            st_d.left  = {1'b0, start_len[LEN4_W-1:LEN3_W]} + NSUB_W'(1);
            st_d.tail  = start_len[LEN3_W-1:0];
            st_d.valid = 1'b1;
        end else if (st_q.valid && m_awready) begin
            st_d.addr  = st_q.addr + (AW'(SUB_BEATS) << beat_size);
            st_d.left  = st_q.left - NSUB_W'(1);
            st_d.valid = (st_q.left > NSUB_W'(1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign m_awaddr  = st_q.addr;
    assign m_awvalid = st_q.valid;
    assign m_awlen   = (st_q.left == NSUB_W'(1)) ? st_q.tail : LEN3_W'(SUB_BEATS - 1);

    // R9
    aw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid && !m_awready |=> m_awvalid && $stable(m_awaddr) && $stable(m_awlen));
endmodule

// File: rtl/bsb_w_frame.sv
module bsb_w_frame
    import bsb_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [LEN4_W-1:0] start_len,
    input  logic [DW-1:0]     s_wdata,
    input  logic [DW/8-1:0]   s_wstrb,
    input  logic              s_wlast,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [DW-1:0]     m_wdata,
    output logic [DW/8-1:0]   m_wstrb,
    output logic              m_wlast,
    output logic              m_wvalid,
    input  logic              m_wready
);
    typedef struct packed {
        logic [BEAT_W-1:0] left;
        logic [LEN3_W-1:0] sub;
    } frame_t;

    frame_t fr_d, fr_q;
    logic   open;
    logic   fire;

    assign open     = (fr_q.left != '0);
    assign m_wvalid = s_wvalid && open;
    assign s_wready = m_wready && open;
    assign m_wdata  = s_wdata;
    assign m_wstrb  = s_wstrb;
    assign m_wlast  = (fr_q.sub == LEN3_W'(SUB_BEATS - 1)) || (fr_q.left == BEAT_W'(1));
    assign fire     = m_wvalid && m_wready;

    always_comb begin
        fr_d = fr_q;
        if (start) begin
            fr_d.left = {1'b0, start_len} + BEAT_W'(1);
            fr_d.sub  = '0;
        end else if (fire) begin
            fr_d.left = fr_q.left - BEAT_W'(1);
            fr_d.sub  = fr_q.sub + LEN3_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) fr_q <= '0;
        else        fr_q <= fr_d;
    end

    // R6
    burst_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire && s_wlast |-> m_wlast);
    // R5
    no_stray_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !open |-> !m_wvalid && !s_wready);
endmodule

// File: rtl/bsb_b_merge.sv
module bsb_b_merge
    import bsb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [NSUB_W-1:0] start_nsub,
    input  logic [1:0]        m_bresp,
    input  logic              m_bvalid,
    output logic              m_bready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    output logic              done
);
    typedef struct packed {
        logic [NSUB_W-1:0] left;
        logic [1:0]        worst;
        logic              out;
    } merge_t;

    merge_t mg_d, mg_q;

    assign m_bready = (mg_q.left != '0);
    assign s_bvalid = mg_q.out;
    assign s_bresp  = mg_q.worst;
    assign done     = mg_q.out && s_bready;

    always_comb begin
        mg_d = mg_q;
        if (start) begin
            mg_d.left  = start_nsub;
            mg_d.worst = RSP_OKAY;
            mg_d.out   = 1'b0;
        end else if (m_bvalid && m_bready) begin
            mg_d.worst = rsp_worse(mg_q.worst, m_bresp);
            mg_d.left  = mg_q.left - NSUB_W'(1);
            mg_d.out   = (mg_q.left == NSUB_W'(1));
        end else if (done) begin
            mg_d.out   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mg_q <= '0;
        else        mg_q <= mg_d;
    end

    // R9
    b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid && !s_bready |=> s_bvalid && $stable(s_bresp));
    // R8
    b_severity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_bvalid && m_bready |=> s_bresp >= $past(m_bresp));
endmodule

// File: rtl/axi4to3_wr_bridge.sv
module axi4to3_wr_bridge
    import bsb_pkg::*;
#(
    parameter int IDW = 4,
    parameter int AW  = 32,
    parameter int DW  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDW-1:0]    s_awid,
    input  logic [AW-1:0]     s_awaddr,
    input  logic [7:0]        s_awlen,
    input  logic [2:0]        s_awsize,
    input  logic [1:0]        s_awburst,
    input  logic              s_awlock,
    input  logic [3:0]        s_awcache,
    input  logic [2:0]        s_awprot,
    input  logic [3:0]        s_awqos,
    input  logic [3:0]        s_awregion,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [DW-1:0]     s_wdata,
    input  logic [DW/8-1:0]   s_wstrb,
    input  logic              s_wlast,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [IDW-1:0]    s_bid,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    output logic [IDW-1:0]    m_awid,
    output logic [AW-1:0]     m_awaddr,
    output logic [3:0]        m_awlen,
    output logic [2:0]        m_awsize,
    output logic [1:0]        m_awburst,
    output logic [1:0]        m_awlock,
    output logic [3:0]        m_awcache,
    output logic [2:0]        m_awprot,
    output logic              m_awvalid,
    input  logic              m_awready,
    output logic [IDW-1:0]    m_wid,
    output logic [DW-1:0]     m_wdata,
    output logic [DW/8-1:0]   m_wstrb,
    output logic              m_wlast,
    output logic              m_wvalid,
    input  logic              m_wready,
    input  logic [IDW-1:0]    m_bid,
    input  logic [1:0]        m_bresp,
    input  logic              m_bvalid,
    output logic              m_bready
);
    typedef struct packed {
        logic [IDW-1:0] id;
        logic [2:0]     size;
        logic [1:0]     burst;
        logic           lock;
        logic [3:0]     cache;
        logic [2:0]     prot;
    } attr_t;

    typedef struct packed {
        attr_t attr;
        logic  busy;
    } top_t;

    top_t              tp_d, tp_q;
    logic              start;
    logic              done;
    logic [NSUB_W-1:0] nsub;

    assign s_awready = !tp_q.busy;
    assign start     = s_awvalid && s_awready;
    assign nsub      = {1'b0, s_awlen[LEN4_W-1:LEN3_W]} + NSUB_W'(1);

    always_comb begin
        tp_d = tp_q;
        if (start) begin
            tp_d.busy       = 1'b1;
            tp_d.attr.id    = s_awid;
            tp_d.attr.size  = s_awsize;
            tp_d.attr.burst = s_awburst;
            tp_d.attr.lock  = s_awlock;
            tp_d.attr.cache = s_awcache;
            tp_d.attr.prot  = s_awprot;
        end else if (done) begin
            tp_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tp_q <= '0;
        else        tp_q <= tp_d;
    end

    assign m_awid    = tp_q.attr.id;
    assign m_awsize  = tp_q.attr.size;
    assign m_awburst = tp_q.attr.burst;
    assign m_awlock  = {1'b0, tp_q.attr.lock};
    assign m_awcache = tp_q.attr.cache;
    assign m_awprot  = tp_q.attr.prot;
    assign m_wid     = tp_q.attr.id;
    assign s_bid     = tp_q.attr.id;

    bsb_aw_split #(.AW(AW)) u_split (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_addr (s_awaddr),
        .start_len  (s_awlen),
        .beat_size  (tp_q.attr.size),
        .m_awaddr   (m_awaddr),
        .m_awlen    (m_awlen),
        .m_awvalid  (m_awvalid),
        .m_awready  (m_awready)
    );

    bsb_w_frame #(.DW(DW)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_len (s_awlen),
        .s_wdata   (s_wdata),
        .s_wstrb   (s_wstrb),
        .s_wlast   (s_wlast),
        .s_wvalid  (s_wvalid),
        .s_wready  (s_wready),
        .m_wdata   (m_wdata),
        .m_wstrb   (m_wstrb),
        .m_wlast   (m_wlast),
        .m_wvalid  (m_wvalid),
        .m_wready  (m_wready)
    );

    bsb_b_merge u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_nsub (nsub),
        .m_bresp    (m_bresp),
        .m_bvalid   (m_bvalid),
        .m_bready   (m_bready),
        .s_bresp    (s_bresp),
        .s_bvalid   (s_bvalid),
        .s_bready   (s_bready),
        .done       (done)
    );

    // R7
    merge_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_bvalid |-> !m_awvalid && !m_wvalid && !m_bready);
    // R10
    single_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !s_awready);
    // R7
    sub_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_bvalid && m_bready |-> m_bid == s_bid);
    // R4
    dropped_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !$isunknown({s_awqos, s_awregion}));
endmodule

// File: tb/axi4to3_wr_bridge_test.sv
`timescale 1ns/100ps
module axi4to3_wr_bridge_test;
    localparam int IDW = 4;
    localparam int AW  = 32;
    localparam int DW  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [IDW-1:0] s_awid = '0;
    logic [AW-1:0]  s_awaddr = '0;
    logic [7:0]     s_awlen = '0;
    logic [2:0]     s_awsize = '0;
    logic [1:0]     s_awburst = 2'b01;
    logic           s_awlock = 1'b0;
    logic [3:0]     s_awcache = '0;
    logic [2:0]     s_awprot = '0;
    logic [3:0]     s_awqos = '0;
    logic [3:0]     s_awregion = '0;
    logic           s_awvalid = 1'b0;
    logic           s_awready;
    logic [DW-1:0]  s_wdata = '0;
    logic [DW/8-1:0] s_wstrb = '0;
    logic           s_wlast = 1'b0;
    logic           s_wvalid = 1'b0;
    logic           s_wready;
    logic [IDW-1:0] s_bid;
    logic [1:0]     s_bresp;
    logic           s_bvalid;
    logic           s_bready = 1'b0;
    logic [IDW-1:0] m_awid;
    logic [AW-1:0]  m_awaddr;
    logic [3:0]     m_awlen;
    logic [2:0]     m_awsize;
    logic [1:0]     m_awburst;
    logic [1:0]     m_awlock;
    logic [3:0]     m_awcache;
    logic [2:0]     m_awprot;
    logic           m_awvalid;
    logic           m_awready = 1'b1;
    logic [IDW-1:0] m_wid;
    logic [DW-1:0]  m_wdata;
    logic [DW/8-1:0] m_wstrb;
    logic           m_wlast;
    logic           m_wvalid;
    logic           m_wready = 1'b1;
    logic [IDW-1:0] m_bid = '0;
    logic [1:0]     m_bresp = '0;
    logic           m_bvalid = 1'b0;
    logic           m_bready;

    axi4to3_wr_bridge #(.IDW(IDW), .AW(AW), .DW(DW)) uut (.*);

    int vectors = 0;
    int miscompares = 0;

    // subordinate-side logs
    logic [AW-1:0]  aw_addr_log [0:31];
    logic [3:0]     aw_len_log  [0:31];
    logic [IDW-1:0] aw_id_log   [0:31];
    logic [1:0]     aw_lock_log [0:31];
    logic [2:0]     aw_size_log [0:31];
    logic [3:0]     aw_cache_log[0:31];
    logic [2:0]     aw_prot_log [0:31];
    logic [DW-1:0]  w_data_log  [0:299];
    logic [IDW-1:0] w_id_log    [0:299];
    logic           w_last_log  [0:299];
    logic [1:0]     plan        [0:15];
    int aw_n = 0, w_n = 0, wl_seen = 0, b_sent = 0;
    int exp_nsub = 0, early = 0, unstable = 0;
    logic stall = 1'b0;
    logic b_fire = 1'b0;
    logic [IDW-1:0] cur_id = '0;

    task automatic chk(input logic ok, input string tag, input longint act, input longint expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    function automatic logic [DW-1:0] pat(input logic [IDW-1:0] id, input int k);
        return 32'hA500_0000 ^ (32'(id) << 16) ^ 32'(k * 7 + 1);
    endfunction

    // subordinate ready pacing
    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk); #1;
            cyc++;
            m_awready = stall ? (cyc % 3 == 0) : 1'b1;
            m_wready  = stall ? (cyc % 2 == 0) : 1'b1;
        end
    end

    // monitors, sampled one ns before each rising edge
    initial begin
        logic pv = 1'b0, pr = 1'b0;
        logic [AW-1:0] pa = '0;
        logic [3:0] pl = '0;
        forever begin
            @(negedge clk); #1;
            if (rst_n) begin
                if (pv && !pr && !(m_awvalid && m_awaddr == pa && m_awlen == pl)) unstable++;
                pv = m_awvalid; pr = m_awready; pa = m_awaddr; pl = m_awlen;
                if (m_awvalid && m_awready) begin
                    aw_addr_log[aw_n] = m_awaddr; aw_len_log[aw_n] = m_awlen;
                    aw_id_log[aw_n] = m_awid; aw_lock_log[aw_n] = m_awlock;
                    aw_size_log[aw_n] = m_awsize; aw_cache_log[aw_n] = m_awcache;
                    aw_prot_log[aw_n] = m_awprot;
                    aw_n++;
                end
                if (m_wvalid && m_wready) begin
                    w_data_log[w_n] = m_wdata; w_id_log[w_n] = m_wid; w_last_log[w_n] = m_wlast;
                    w_n++;
                    if (m_wlast) wl_seen++;
                end
                b_fire = m_bvalid && m_bready;
                if (s_bvalid && b_sent < exp_nsub) early++;
            end
        end
    end

    // subordinate response generator
    initial begin
        forever begin
            @(posedge clk); #1;
            if (b_fire) begin b_sent++; m_bvalid = 1'b0; end
            if (!m_bvalid && b_sent < wl_seen) begin
                m_bvalid = 1'b1; m_bresp = plan[b_sent]; m_bid = cur_id;
            end
        end
    end

    task automatic aw_send(input logic [IDW-1:0] id, input logic [AW-1:0] a, input logic [7:0] l,
                           input logic [2:0] sz, input logic lk, input logic [3:0] q, input logic [3:0] rg);
        logic hs = 1'b0;
        s_awid = id; s_awaddr = a; s_awlen = l; s_awsize = sz; s_awlock = lk;
        s_awcache = 4'h3; s_awprot = 3'h2; s_awqos = q; s_awregion = rg; s_awvalid = 1'b1;
        while (!hs) begin @(negedge clk); #1; hs = s_awready; @(posedge clk); #1; end
        s_awvalid = 1'b0;
        @(negedge clk); #1;
        chk(!s_awready, "R10 awready low while busy", s_awready, 0);
    endtask

    task automatic w_send(input logic [IDW-1:0] id, input int nbeats);
        for (int k = 0; k < nbeats; k++) begin
            logic hs = 1'b0;
            s_wvalid = 1'b1; s_wdata = pat(id, k); s_wstrb = '1; s_wlast = (k == nbeats - 1);
            while (!hs) begin @(negedge clk); #1; hs = s_wready; @(posedge clk); #1; end
        end
        s_wvalid = 1'b0; s_wlast = 1'b0;
    endtask

    task automatic run(input string nm, input logic [IDW-1:0] id, input logic [AW-1:0] a,
                       input logic [7:0] l, input logic [2:0] sz, input logic lk,
                       input logic [3:0] q, input logic [3:0] rg, input logic stl, input logic [1:0] eresp);
        int n = int'(l) / 16 + 1;
        logic [1:0] got_r; logic [IDW-1:0] got_id; int sent_at;
        @(posedge clk); #1;
        aw_n = 0; w_n = 0; wl_seen = 0; b_sent = 0; early = 0; unstable = 0;
        exp_nsub = n; cur_id = id; stall = stl;
        fork
            aw_send(id, a, l, sz, lk, q, rg);
            w_send(id, int'(l) + 1);
        join
        while (!s_bvalid) begin @(negedge clk); #1; end
        got_r = s_bresp; got_id = s_bid; sent_at = b_sent;
        if (stl) begin
            repeat (3) begin @(posedge clk); #1; end
            @(negedge clk); #1;
            chk(s_bvalid && s_bresp == got_r, "R9 merged B held until ready", s_bresp, got_r);
        end
        @(posedge clk); #1; s_bready = 1'b1;
        @(posedge clk); #1; s_bready = 1'b0;
        @(negedge clk); #1;
        chk(!s_bvalid, {"R7 single B ", nm}, s_bvalid, 0);
        chk(s_awready, "R10 awready back after B", s_awready, 1);
        chk(aw_n == n, {"R1 sub-burst count ", nm}, aw_n, n);
        for (int k = 0; k < n && k < aw_n; k++) begin
            logic [3:0] el = (k == n - 1) ? l[3:0] : 4'd15;
            logic [AW-1:0] ea = a + AW'(k) * (AW'(16) << sz);
            chk(aw_len_log[k] == el, {"R1 sub len ", nm}, aw_len_log[k], el);
            chk(aw_addr_log[k] == ea, {"R2 sub addr ", nm}, aw_addr_log[k], ea);
            chk(aw_id_log[k] == id && aw_size_log[k] == sz && aw_cache_log[k] == 4'h3
                && aw_prot_log[k] == 3'h2, {"R3 attrs ", nm}, aw_id_log[k], id);
            chk(aw_lock_log[k] == {1'b0, lk}, {"R3 lock code ", nm}, aw_lock_log[k], {1'b0, lk});
        end
        chk(w_n == int'(l) + 1, {"R5 beat count ", nm}, w_n, int'(l) + 1);
        for (int k = 0; k < w_n && k < 300; k++) begin
            logic el = (k % 16 == 15) || (k == int'(l));
            chk(w_data_log[k] == pat(id, k) && w_id_log[k] == id, {"R5 data/wid ", nm}, w_data_log[k], pat(id, k));
            chk(w_last_log[k] == el, {"R6 wlast ", nm}, w_last_log[k], el);
        end
        chk(sent_at == n && early == 0, {"R7 B after all subs ", nm}, sent_at, n);
        chk(got_id == id, {"R7 bid ", nm}, got_id, id);
        chk(got_r == eresp, {"R8 merged resp ", nm}, got_r, eresp);
        chk(unstable == 0, {"R9 AW stable ", nm}, unstable, 0);
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk(s_awready == 1'b1, "R11 awready after reset", s_awready, 1);
        chk(!m_awvalid && !m_wvalid && !s_wready, "R11 downstream idle", m_awvalid, 0);
        chk(!s_bvalid, "R11 no response", s_bvalid, 0);
    endtask

    task automatic t_short();
        for (int k = 0; k < 16; k++) plan[k] = 2'b00;
        run("short", 4'h3, 32'h0000_1000, 8'd3, 3'd2, 1'b0, 4'h0, 4'h0, 1'b0, 2'b00);
    endtask

    task automatic t_exact16();
        for (int k = 0; k < 16; k++) plan[k] = 2'b00;
        run("len16", 4'h5, 32'h0000_2000, 8'd15, 3'd2, 1'b0, 4'h0, 4'h0, 1'b0, 2'b00);
    endtask

    task automatic t_seventeen();
        for (int k = 0; k < 16; k++) plan[k] = 2'b00;
        run("len17", 4'h6, 32'h0000_3000, 8'd16, 3'd1, 1'b0, 4'h0, 4'h0, 1'b0, 2'b00);
    endtask

    task automatic t_long_stall();
        for (int k = 0; k < 16; k++) plan[k] = 2'b00;
        plan[1] = 2'b10;
        run("len41 stalled", 4'h9, 32'h0001_0000, 8'd40, 3'd3, 1'b0, 4'h0, 4'h0, 1'b1, 2'b10);
    endtask

    task automatic t_max();
        for (int k = 0; k < 16; k++) plan[k] = 2'b00;
        plan[4] = 2'b11; plan[9] = 2'b10; plan[15] = 2'b01;
        run("len256", 4'hC, 32'h0010_0000, 8'd255, 3'd2, 1'b0, 4'h0, 4'h0, 1'b1, 2'b11);
    endtask

    task automatic t_exclusive();
        for (int k = 0; k < 16; k++) plan[k] = 2'b01;
        run("exclusive", 4'h1, 32'h0000_0400, 8'd7, 3'd2, 1'b1, 4'h0, 4'h0, 1'b0, 2'b01);
    endtask

    task automatic t_qos_region();
        for (int k = 0; k < 16; k++) plan[k] = 2'b00;
        run("R4 qos/region set", 4'h2, 32'h0000_5000, 8'd20, 3'd2, 1'b0, 4'hF, 4'hA, 1'b0, 2'b00);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_short();
        t_exact16();
        t_seventeen();
        t_long_stall();
        t_max();
        t_exclusive();
        t_qos_region();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule